// File: doc/BRIEF.md
# Fan PWM Generator with Register Control

This block drives a single two-wire fan with a pulse-width modulated signal of fixed frequency (25 Hz) and active-high polarity. Software programs it through two 32-bit registers on a simple word-aligned bus with separate read and write strobes. The first register holds the run bit, a mode bit (only the two-wire value, 0, has an effect) and an 8-bit duty value. The second register holds a 16-bit maximum fan speed value that the block only stores and returns on reads.

The fan period is built from 255 equal steps. Each step lasts `CLK_HZ/(25*255)` clock cycles, so the period is exactly 255 step lengths. The output is high while the step index is below the duty value. A duty change is used at once, so the period in which it lands can mix the old and new settings. Clearing the run bit drives the output low and parks the counters. Setting the run bit again starts a fresh period with the high phase first.

Top module: `fan_pwm_gen`

## Requirements
- R1: After synchronous reset, both registers read 0x00000000 and `pwm_out` is 0.
- R2: The control register at byte address 0x0 holds run in bit 0, mode in bit 1 and duty in bits 23:16. Reads return those fields in the same positions, and all other bits read 0 whatever was written to them.
- R3: The speed-limit register at byte address 0x4 stores bits 15:0 of a write and returns them with bits 31:16 reading 0. A write to any other address changes no register, and a read of any other address returns 0.
- R4: While running, every window of 255*STEP_CYC consecutive cycles holds exactly duty*STEP_CYC high cycles of `pwm_out`. With duty 0 the output never goes high, and with duty 255 it never goes low.
- R5: In the cycle after a write that clears the run bit, `pwm_out` is 0. It stays 0 while the run bit is 0, and the stored duty is kept.
- R6: A write that takes the run bit from 0 to 1 restarts the period at step 0, so with a non-zero duty `pwm_out` is 1 in the following cycle.
- R7: A duty write takes effect in the cycle after the write, even in the middle of a period.
- R8: Read data is registered. `bus_rdata` updates in the cycle after `bus_rd` is asserted and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 1 | Fan drive, high during the active phase |

## Verification
The bench writes all ones to both registers and checks that only the defined fields come back. A design that does not mask unused bits reads back stray ones. It writes to an address that maps to no register and checks that the control register is unchanged. It measures high time over a full period for duty values 0, 1, 128 and 255. A compare off by one step shows up as one step length too many or too few, or as a glitch at the two extremes. It clears and then sets the run bit in the middle of a period. A design that keeps the old phase starts low instead of high, and one that ignores the run bit keeps toggling. It also changes the duty while the output is high and checks that the output falls in the next cycle rather than at the next period boundary.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
    localparam int FAN_HZ     = 25;
    localparam int STEPS      = 255;
    localparam int REG_W      = 32;
    localparam int DUTY_W     = 8;
    localparam int RPM_W      = 16;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_LIMIT = 8'h04;

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
        logic              mode;
        logic              run;
    } ctrl_t;

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        logic [REG_W-1:0] w;
        w        = '0;
        w[0]     = c.run;
        w[1]     = c.mode;
        w[23:16] = c.duty;
        return w;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.run  = w[0];
        c.mode = w[1];
        c.duty = w[23:16];
        return c;
    endfunction
endpackage

// File: rtl/fan_pwm_regs.sv
module fan_pwm_regs
    import fan_pwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [REG_W-1:0]  bus_rdata,
    output ctrl_t             ctrl
);
    logic [RPM_W-1:0] rpm_limit;
    logic             hit_ctrl;
    logic             hit_limit;
    logic [REG_W-1:0] rd_mux;

    assign hit_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_limit = (bus_addr == ADDR_W'(OFS_LIMIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            rpm_limit <= '0;
        end else if (bus_wr) begin
            if (hit_ctrl)  ctrl      <= unpack_ctrl(bus_wdata);
            if (hit_limit) rpm_limit <= bus_wdata[RPM_W-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (hit_ctrl)       rd_mux = pack_ctrl(ctrl);
        else if (hit_limit) rd_mux = {{(REG_W-RPM_W){1'b0}}, rpm_limit};
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/fan_pwm_timebase.sv
module fan_pwm_timebase
    import fan_pwm_pkg::*;
#(
    parameter int STEP_CYC = 4,
    parameter int PRE_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    output logic [DUTY_W-1:0] step,
    output logic [PRE_W-1:0]  pre
);
    localparam logic [DUTY_W-1:0] STEP_LAST = DUTY_W'(STEPS - 1);
    localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(STEP_CYC - 1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre  <= '0;
            step <= '0;
        end else if (pre == PRE_LAST) begin
            pre  <= '0;
            step <= (step == STEP_LAST) ? '0 : step + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end
endmodule

// File: rtl/fan_pwm_compare.sv
module fan_pwm_compare
    import fan_pwm_pkg::*;
(
    input  logic              run,
    input  logic [DUTY_W-1:0] duty,
    input  logic [DUTY_W-1:0] step,
    output logic              pwm_out
);
    assign pwm_out = run && (step < duty);
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
    import fan_pwm_pkg::*;
#(
    parameter int CLK_HZ = 25500,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              pwm_out
);
    localparam int STEP_CYC = (CLK_HZ / (FAN_HZ * STEPS)) < 1 ? 1 : CLK_HZ / (FAN_HZ * STEPS);
    localparam int PRE_W    = $clog2(STEP_CYC + 1);

    ctrl_t             ctrl;
    logic              run;
    logic [DUTY_W-1:0] duty;
    logic [DUTY_W-1:0] step;
    logic [PRE_W-1:0]  pre;

    assign run  = ctrl.run;
    assign duty = ctrl.duty;

    fan_pwm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rd   (bus_rd),
        .bus_rdata(bus_rdata),
        .ctrl     (ctrl)
    );

    fan_pwm_timebase #(.STEP_CYC(STEP_CYC), .PRE_W(PRE_W)) u_tb (
        .clk (clk),
        .rst (rst),
        .run (run),
        .step(step),
        .pre (pre)
    );

    fan_pwm_compare u_cmp (
        .run    (run),
        .duty   (duty),
        .step   (step),
        .pwm_out(pwm_out)
    );
endmodule

// File: rtl/fan_pwm_checker.sv
module fan_pwm_checker #(
    parameter int ADDR_W = 4,
    parameter int PRE_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic [7:0]        duty,
    input logic [7:0]        step,
    input logic [PRE_W-1:0]  pre,
    input logic              pwm_out,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata
);
    AST_OFF_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst) !run |-> !pwm_out); // R5
    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst) duty == 8'd0 |-> !pwm_out); // R4
    AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (rst) (run && duty == 8'hFF) |-> pwm_out); // R4
    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (rst) step != 8'hFF); // R4
    AST_RESTART_ON_RUN: assert property (@(posedge clk) disable iff (rst) $rose(run) |-> (step == 8'd0 && pre == '0)); // R6
    AST_DUTY_AT_ONCE: assert property (@(posedge clk) disable iff (rst) (bus_wr && bus_addr == '0) |=> duty == $past(bus_wdata[23:16])); // R7
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst) !bus_rd |=> $stable(bus_rdata)); // R8
endmodule

bind fan_pwm_gen fan_pwm_checker #(.ADDR_W(ADDR_W), .PRE_W(PRE_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .duty     (duty),
    .step     (step),
    .pre      (pre),
    .pwm_out  (pwm_out),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
);

// File: tb/test_fan_pwm_gen.sv
module test_fan_pwm_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 25500;
    localparam int ADDR_W     = 4;
    localparam int STEP       = CLK_HZ / (25 * 255);
    localparam int PERIOD     = STEP * 255;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_rdata;
    logic              pwm_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic        rd_q = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fan_pwm_gen #(.CLK_HZ(CLK_HZ), .ADDR_W(ADDR_W)) i_fan_pwm_gen (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) rd_q <= bus_rd;

    // monitor: read data is valid at the negedge after the capturing edge
    always @(negedge clk) begin
        if (rd_q) begin
            if (exp_q.size() == 0) check("R8 unexpected read", bus_rdata, 32'h0);
            else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_addr = ADDR_W'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // counts high samples over one full period starting at the current negedge
    task automatic measure(output int highs);
        highs = 0;
        for (int i = 0; i < PERIOD; i++) begin
            if (pwm_out) highs++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        int h;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 pwm after reset", {31'b0, pwm_out}, 32'h0);
        bus_read(8'h00, 32'h0, "R1 ctrl after reset");
        bus_read(8'h04, 32'h0, "R1 limit after reset");

        // R2 / R3 field masking
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_read(8'h00, 32'h00FF_0003, "R2 ctrl mask");
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_read(8'h04, 32'h0000_FFFF, "R3 limit mask");
        bus_write(8'h04, 32'h1234_0FA0);
        bus_read(8'h04, 32'h0000_0FA0, "R3 limit value");
        bus_write(8'h08, 32'h0055_0000);
        bus_read(8'h00, 32'h00FF_0003, "R3 stray write ignored");
        bus_read(8'h08, 32'h0, "R3 unmapped read");
        bus_read(8'h0C, 32'h0, "R3 unmapped read 0xC");

        // R8 holding read data
        @(negedge clk);
        check("R8 rdata holds", bus_rdata, 32'h0);

        // R4 full duty, always high
        measure(h);
        check("R4 duty 255 high count", h, PERIOD);

        // R5 stop
        bus_write(8'h00, 32'h0080_0000);
        check("R5 low after stop", {31'b0, pwm_out}, 32'h0);
        measure(h);
        check("R5 stays low", h, 0);
        bus_read(8'h00, 32'h0080_0000, "R5 duty retained");

        // R6 restart, high phase first; R4 duty 128
        bus_write(8'h00, 32'h0080_0001);
        check("R6 high first", {31'b0, pwm_out}, 32'h1);
        measure(h);
        check("R4 duty 128 high count", h, 128 * STEP);

        // R6 restart mid-period with duty 1
        repeat (333) @(negedge clk);
        bus_write(8'h00, 32'h0001_0000);
        bus_write(8'h00, 32'h0001_0001);
        check("R6 restart duty 1 high first", {31'b0, pwm_out}, 32'h1);
        measure(h);
        check("R4 duty 1 high count", h, STEP);

        // R4 duty 0
        bus_write(8'h00, 32'h0000_0001);
        measure(h);
        check("R4 duty 0 high count", h, 0);

        // R7 mid-period change
        bus_write(8'h00, 32'h0000_0000);
        bus_write(8'h00, 32'h00C8_0001);
        repeat (300) @(negedge clk);
        check("R7 high before change", {31'b0, pwm_out}, 32'h1);
        bus_write(8'h00, 32'h0032_0001);
        check("R7 low right after change", {31'b0, pwm_out}, 32'h0);
        repeat (PERIOD) @(negedge clk);
        measure(h);
        check("R7 new duty steady", h, 50 * STEP);

        repeat (3) @(negedge clk);
        check("R8 all reads answered", exp_q.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule